// File: doc/BRIEF.md
# Switch-on-Miss Thread Controller

This block runs coarse-grain multithreading for a short in-order pipeline with up to four hardware thread contexts. Only one context issues at a time. When the running context reports a cache miss, the controller raises a one-cycle pipeline flush and records the PC of the missing instruction in that context's PC slot, so that instruction is fetched again after the fill. The missing context is parked as waiting, and fetch moves to the nearest ready context in round-robin order after the current one. Fetch stays blanked for a fixed flush penalty, so no useful work from the incoming context completes during that time.

Each context is in one of three states: running, ready or waiting. A miss-completion pulse carries a thread number and moves a waiting context back to ready. If no context is ready when a miss arrives, the controller idles fetch. Once the flush has drained and some fill has made a context ready, that context starts running with no further flush.

Fetch addresses leave on a valid/ready stream. `fetch_valid` is high whenever a context is running and no flush is draining. `fetch_pc` and `active_tid` hold steady while `fetch_valid` is high and `fetch_ready` is low. Each accepted address advances the running context's PC by one instruction. A miss withdraws the offer, and it is the only event that may do so without a handshake. Miss and fill inputs are plain one-cycle strobes with no back-pressure.

Top module: `smt_switch_ctrl`

## Requirements
- R1: After reset, context 0 is running, contexts 1 to N-1 are ready, `flush` is 0, `fetch_valid` is 1, and context t holds PC `BOOT_BASE + t*BOOT_STRIDE`. With defaults these are 0x1000, 0x1100, 0x1200 and 0x1300.
- R2: When a handshake (`fetch_valid` and `fetch_ready`) occurs with no miss, `fetch_pc` advances by `INSTR_BYTES` on the next cycle. When `fetch_valid` is high and `fetch_ready` is low with no miss, `fetch_pc` and `active_tid` hold.
- R3: A miss is accepted only in a cycle with `fetch_valid` high. An accepted miss makes `flush` high for exactly the following cycle, and `flush` is never high otherwise.
- R4: After an accepted miss, `fetch_valid` is low for exactly `FLUSH_CYCLES` cycles (default 4) before any context may fetch.
- R5: On an accepted miss, the next running context is the first ready context found scanning upward from the current number plus one, wrapping modulo N. `active_tid` shows it from the cycle after the miss.
- R6: The PC slot of a context that misses takes `miss_pc`, which overrides any handshake in the same cycle. A context resumes from its own slot when switched in again.
- R7: If no context is ready on an accepted miss, fetch idles after the flush. The first cycle after the flush has drained in which a context is ready, that context starts running on the next cycle, with no flush. The scan starts after the current number and includes the current context last.
- R8: A fill for a context that is not waiting, including the running one, changes no state.
- R9: A miss raised while a flush is draining is ignored. It causes no new flush and no switch, and it does not change the window length.
- R10: A miss raised while fetch is idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Running context's instruction missed this cycle |
| miss_pc | input | PC_W | PC of the instruction that missed |
| fill_valid | input | 1 | A miss has completed |
| fill_tid | input | TID_W | Context whose miss completed |
| fetch_valid | output | 1 | Fetch address offered |
| fetch_ready | input | 1 | Fetch address accepted |
| fetch_pc | output | PC_W | PC slot of the active context |
| active_tid | output | TID_W | Number of the active or last active context |
| flush | output | 1 | One-cycle pipeline flush pulse |

## Verification
The bench walks a sequence that wraps the round-robin scan from context 3 to context 0. A scan that never wraps would strand fetch on an idle context. The sequence places a miss inside a flush window, where a design that re-arms would stretch the blanking or switch twice. It sends a fill to a ready context and another to the running one, where a design that ignores the waiting state would demote or duplicate a context. It also drives every context into the waiting state, then frees one during the flush. A design that restarts early would fetch during the penalty, and one that flushes again on restart would lose cycles.

// File: rtl/smt_pkg.sv
package smt_pkg;
  // Per-context scheduling state.
  typedef enum logic [1:0] {
    CTX_READY = 2'd0,
    CTX_RUN   = 2'd1,
    CTX_WAIT  = 2'd2
  } ctx_state_e;
endpackage

// File: rtl/smt_rr_pick.sv
// Nearest set candidate after `base`, wrapping; `base` itself is checked last.
module smt_rr_pick #(
  parameter int N_THREADS = 4,
  localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic [N_THREADS-1:0] cand,
  input  logic [TID_W-1:0]     base,
  output logic                 found,
  output logic [TID_W-1:0]     pick
);
  int idx;

  always_comb begin
    found = 1'b0;
    pick  = base;
    idx   = 0;
    // Walk from farthest to nearest so the nearest candidate wins.
    for (int k = N_THREADS; k >= 1; k--) begin
      idx = (int'(base) + k) % N_THREADS;
      if (cand[idx]) begin
        found = 1'b1;
        pick  = idx[TID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/smt_ctx_bank.sv
// Per-context state and PC slots.
module smt_ctx_bank
  import smt_pkg::*;
#(
  parameter int N_THREADS   = 4,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] BOOT_BASE   = 32'h0000_1000,
  parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_0100,
  localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [TID_W-1:0]               cur_tid,
  input  logic                           miss_take,
  input  logic [PC_W-1:0]                miss_pc,
  input  logic                           fetch_fire,
  input  logic                           start_take,
  input  logic [TID_W-1:0]               start_tid,
  input  logic                           fill_valid,
  input  logic [TID_W-1:0]               fill_tid,
  output logic [N_THREADS-1:0]           ready_vec,
  output logic [N_THREADS-1:0][PC_W-1:0] pc_vec
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  for (genvar t = 0; t < N_THREADS; t++) begin : g_ctx
    localparam logic [TID_W-1:0] MY_TID = TID_W'(t);
    localparam logic [PC_W-1:0]  RST_PC = BOOT_BASE + PC_W'(t) * BOOT_STRIDE;
    localparam ctx_state_e       RST_ST = (t == 0) ? CTX_RUN : CTX_READY;

    ctx_state_e      st_q;
    logic [PC_W-1:0] pc_q;
    logic            is_cur;

    assign is_cur = (cur_tid == MY_TID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= RST_ST;
        pc_q <= RST_PC;
      end else begin
        if (miss_take && is_cur) begin
          st_q <= CTX_WAIT;
          pc_q <= miss_pc;
        end else begin
          if (start_take && start_tid == MY_TID) begin
            st_q <= CTX_RUN;
          end else if (fill_valid && fill_tid == MY_TID && st_q == CTX_WAIT) begin
            st_q <= CTX_READY;
          end
          if (fetch_fire && is_cur) begin
            pc_q <= pc_q + STEP;
          end
        end
      end
    end

    assign ready_vec[t] = (st_q == CTX_READY);
    assign pc_vec[t]    = pc_q;
  end
endmodule

// File: rtl/smt_flush_timer.sv
// Flush pulse plus a countdown that blanks fetch for the penalty window.
module smt_flush_timer #(
  parameter int FLUSH_CYCLES = 4,
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic flush
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(FLUSH_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= load;
      if (load) begin
        cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy  = (cnt_q != '0);
  assign flush = flush_q;
endmodule

// File: rtl/smt_switch_ctrl.sv
module smt_switch_ctrl
  import smt_pkg::*;
#(
  parameter int N_THREADS    = 4,
  parameter int PC_W         = 32,
  parameter int FLUSH_CYCLES = 4,
  parameter int INSTR_BYTES  = 4,
  parameter logic [PC_W-1:0] BOOT_BASE   = 32'h0000_1000,
  parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_0100,
  localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [PC_W-1:0]  miss_pc,
  input  logic             fill_valid,
  input  logic [TID_W-1:0] fill_tid,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [PC_W-1:0]  fetch_pc,
  output logic [TID_W-1:0] active_tid,
  output logic             flush
);
  logic [TID_W-1:0]               cur_q;
  logic                           run_q;
  logic                           busy;
  logic                           miss_take;
  logic                           fetch_fire;
  logic                           idle_start;
  logic                           start_take;
  logic                           found;
  logic [TID_W-1:0]               pick;
  logic [N_THREADS-1:0]           ready_vec;
  logic [N_THREADS-1:0][PC_W-1:0] pc_vec;

  // A miss counts only while this context is actually fetching.
  assign fetch_valid = run_q && !busy;
  assign miss_take   = miss_valid && fetch_valid;
  assign fetch_fire  = fetch_valid && fetch_ready && !miss_valid;
  assign idle_start  = !run_q && !busy && found;
  assign start_take  = found && (miss_take || idle_start);

  smt_rr_pick #(.N_THREADS(N_THREADS)) pick_i (
    .cand  (ready_vec),
    .base  (cur_q),
    .found (found),
    .pick  (pick)
  );

  smt_ctx_bank #(
    .N_THREADS   (N_THREADS),
    .PC_W        (PC_W),
    .INSTR_BYTES (INSTR_BYTES),
    .BOOT_BASE   (BOOT_BASE),
    .BOOT_STRIDE (BOOT_STRIDE)
  ) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_tid    (cur_q),
    .miss_take  (miss_take),
    .miss_pc    (miss_pc),
    .fetch_fire (fetch_fire),
    .start_take (start_take),
    .start_tid  (pick),
    .fill_valid (fill_valid),
    .fill_tid   (fill_tid),
    .ready_vec  (ready_vec),
    .pc_vec     (pc_vec)
  );

  smt_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (miss_take),
    .busy  (busy),
    .flush (flush)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      run_q <= 1'b1;
    end else if (miss_take) begin
      run_q <= found;
      if (found) cur_q <= pick;
    end else if (idle_start) begin
      run_q <= 1'b1;
      cur_q <= pick;
    end
  end

  assign fetch_pc   = pc_vec[cur_q];
  assign active_tid = cur_q;
endmodule

// File: rtl/smt_switch_ctrl_chk.sv
module smt_switch_ctrl_chk #(
  parameter int PC_W         = 32,
  parameter int TID_W        = 2,
  parameter int FLUSH_CYCLES = 4,
  parameter int INSTR_BYTES  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [TID_W-1:0] active_tid,
  input logic             flush
);
  int win_q;

  // Independent count of blanking cycles left after an accepted miss.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 0;
    else if (miss_valid && fetch_valid) win_q <= FLUSH_CYCLES;
    else if (win_q != 0) win_q <= win_q - 1;
  end

  p_flush_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  p_flush_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(miss_valid && fetch_valid));

  p_flush_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && fetch_valid) |=> flush);

  p_blank_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != 0) |-> !fetch_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !miss_valid) |=>
      (fetch_valid && $stable(fetch_pc) && $stable(active_tid)));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !miss_valid) |=>
      (fetch_valid && fetch_pc == $past(fetch_pc) + PC_W'(INSTR_BYTES)));
endmodule

bind smt_switch_ctrl smt_switch_ctrl_chk #(
  .PC_W         (PC_W),
  .TID_W        (TID_W),
  .FLUSH_CYCLES (FLUSH_CYCLES),
  .INSTR_BYTES  (INSTR_BYTES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_valid  (miss_valid),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_pc    (fetch_pc),
  .active_tid  (active_tid),
  .flush       (flush)
);

// File: tb/smt_switch_ctrl_tb_top.sv
module smt_switch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS      = 40;

  // Row: inputs for the cycle, then outputs expected during that cycle.
  typedef struct packed {
    logic        miss;
    logic [31:0] mpc;
    logic        fv_in;
    logic [1:0]  ftid;
    logic        rdy;
    logic        e_fv;
    logic [1:0]  e_tid;
    logic [31:0] e_pc;
    logic        e_fl;
  } row_t;

  function automatic row_t V(input logic m, input logic [31:0] mpc,
                             input logic fv, input logic [1:0] ft, input logic r,
                             input logic efv, input logic [1:0] et,
                             input logic [31:0] epc, input logic efl);
    row_t x;
    x.miss = m; x.mpc = mpc; x.fv_in = fv; x.ftid = ft; x.rdy = r;
    x.e_fv = efv; x.e_tid = et; x.e_pc = epc; x.e_fl = efl;
    return x;
  endfunction

  localparam row_t TABLE [NROWS] = '{
    V(0,0,0,0,1, 1,0,32'h1000,0),        // 0  R1 boot state, R2 accept
    V(0,0,0,0,0, 1,0,32'h1004,0),        // 1  R2 advanced, now stalled
    V(0,0,0,0,1, 1,0,32'h1004,0),        // 2  R2 held under back-pressure
    V(1,32'h1008,0,0,1, 1,0,32'h1008,0), // 3  R6 miss beats handshake
    V(1,32'hdead,0,0,1, 0,1,32'h1100,1), // 4  R3 flush, R5 ctx1, R9 miss ignored
    V(0,0,1,2,1, 0,1,32'h1100,0),        // 5  R8 fill to ready ctx2
    V(0,0,0,0,1, 0,1,32'h1100,0),        // 6  R4 blank
    V(0,0,0,0,1, 0,1,32'h1100,0),        // 7  R4 blank
    V(0,0,0,0,1, 1,1,32'h1100,0),        // 8  R4 fetch resumes
    V(1,32'h1104,0,0,1, 1,1,32'h1104,0), // 9  miss ctx1
    V(0,0,1,0,1, 0,2,32'h1200,1),        // 10 R5 ctx2; fill ctx0
    V(0,0,0,0,1, 0,2,32'h1200,0),
    V(0,0,0,0,1, 0,2,32'h1200,0),
    V(0,0,0,0,1, 0,2,32'h1200,0),
    V(1,32'h1200,0,0,1, 1,2,32'h1200,0), // 14 miss ctx2
    V(0,0,0,0,1, 0,3,32'h1300,1),        // 15 R5 ctx3
    V(0,0,0,0,1, 0,3,32'h1300,0),
    V(0,0,0,0,1, 0,3,32'h1300,0),
    V(0,0,0,0,1, 0,3,32'h1300,0),
    V(1,32'h1300,0,0,1, 1,3,32'h1300,0), // 19 miss ctx3
    V(0,0,1,1,1, 0,0,32'h1008,1),        // 20 R5 wrap to ctx0; fill ctx1
    V(0,0,0,0,1, 0,0,32'h1008,0),
    V(0,0,0,0,1, 0,0,32'h1008,0),
    V(0,0,0,0,1, 0,0,32'h1008,0),
    V(0,0,0,0,1, 1,0,32'h1008,0),        // 24 R6 resumes at miss PC
    V(1,32'h100c,0,0,1, 1,0,32'h100c,0), // 25 miss ctx0
    V(0,0,0,0,1, 0,1,32'h1104,1),        // 26 R6 ctx1 own PC
    V(0,0,0,0,1, 0,1,32'h1104,0),
    V(0,0,0,0,1, 0,1,32'h1104,0),
    V(0,0,0,0,1, 0,1,32'h1104,0),
    V(1,32'h1104,0,0,1, 1,1,32'h1104,0), // 30 miss with no ready ctx
    V(0,0,0,0,1, 0,1,32'h1104,1),        // 31 R7 flush, idle
    V(0,0,1,3,1, 0,1,32'h1104,0),        // 32 R7 fill ctx3 during flush
    V(0,0,0,0,1, 0,1,32'h1104,0),        // 33 R7 still blank
    V(0,0,0,0,1, 0,1,32'h1104,0),        // 34 R7 still blank
    V(1,32'h2000,0,0,1, 0,1,32'h1104,0), // 35 R10 idle miss ignored
    V(0,0,0,0,0, 1,3,32'h1300,0),        // 36 R7 ctx3 runs, no flush
    V(0,0,1,3,0, 1,3,32'h1300,0),        // 37 R8 fill to running ctx
    V(0,0,0,0,1, 1,3,32'h1300,0),        // 38 R8 still running
    V(0,0,0,0,0, 1,3,32'h1304,0)         // 39 R2 advanced
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_pc = '0;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_tid = '0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_pc;
  logic [1:0]  active_tid;
  logic        flush;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_switch_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_pc     (miss_pc),
    .fill_valid  (fill_valid),
    .fill_tid    (fill_tid),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_pc    (fetch_pc),
    .active_tid  (active_tid),
    .flush       (flush)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input logic efv, input logic [1:0] et,
                          input logic [31:0] epc, input logic efl);
    chk("R4 fetch_valid", 32'(fetch_valid), 32'(efv));
    chk("R5 active_tid",  32'(active_tid),  32'(et));
    chk("R6 fetch_pc",    fetch_pc,         epc);
    chk("R3 flush",       32'(flush),       32'(efl));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_outs(1'b1, 2'd0, 32'h1000, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      chk_outs(TABLE[i].e_fv, TABLE[i].e_tid, TABLE[i].e_pc, TABLE[i].e_fl);
      miss_valid  = TABLE[i].miss;
      miss_pc     = TABLE[i].mpc;
      fill_valid  = TABLE[i].fv_in;
      fill_tid    = TABLE[i].ftid;
      fetch_ready = TABLE[i].rdy;
      @(negedge clk);
    end
    miss_valid = 0; fill_valid = 0; fetch_ready = 0;

    // R1 mid-run reset restores the boot state and all PC slots.
    rst_n = 1'b0;
    @(negedge clk);
    chk_outs(1'b1, 2'd0, 32'h1000, 1'b0);
    rst_n = 1'b1;

    // R1 context 2 boot PC, reached via two misses; R9 single flush.
    miss_valid = 1; miss_pc = 32'h1000;
    @(negedge clk);
    miss_valid = 0;
    chk("R3 flush after miss", 32'(flush), 32'd1);
    chk_outs(1'b0, 2'd1, 32'h1100, 1'b1);
    repeat (4) @(negedge clk);
    chk("R4 fetch back after window", 32'(fetch_valid), 32'd1);
    miss_valid = 1; miss_pc = 32'h1100;
    @(negedge clk);
    miss_valid = 0;
    chk("R1 ctx2 boot PC", fetch_pc, 32'h1200);
    chk("R5 ctx2 selected", 32'(active_tid), 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule